// File: doc/BRIEF.md
# Split-Sum Variable Node Processor

This block performs the variable-node half of an LDPC belief-propagation iteration for one column at a time. A column's edges are divided into a structured subset and a random subset, and the two subsets are served in separate passes. A pass starts with a command that names the node, the subset and the number of edges to serve. The block then takes that many check-to-variable messages on its input stream and adds them up. It records the sum as that subset's partial sum for the node. It then returns one extrinsic variable-to-check message per edge on its output stream, in the order the inputs arrived.

Each outgoing value is the channel LLR of the node, plus the sum of the current pass, plus the partial sum stored earlier for the node's other subset, minus the message of the edge being answered. The result is clipped to 8 bits. Channel LLRs are written through a plain port when a frame is loaded. The stored partial sums stay in place from one pass to the next, so each subset's pass can use the other subset's latest total.

Both streams use valid/ready. A transfer happens on any clock edge where valid and ready are both high. `in_ready` is high only while the read phase of a pass is open. `out_valid` is high only during the write phase, and while it is high and `out_ready` is low the output value is held. The message store behaves as a single-port memory, so the two streams are never open in the same cycle.

Top module: `split_vnode_proc`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `in_ready` and `done` are low. Every stored partial sum is zero.
- R2: `start` is taken only while the block is idle. A `start` during a pass has no effect on that pass's outputs.
- R3: After a `start` with degree d (1..MAX_DEG), `in_ready` is high until exactly d input transfers have been taken. After the last of them, `out_valid` is high in the next cycle.
- R4: Output k (k = 0..d-1) is clip(LLR[node] + S + P_other[node] - m_k). Here S is the sum of the d inputs of the pass, m_k is the k-th input and P_other is the stored partial sum of the other subset. Outputs leave in input order. Message values are 8-bit two's complement.
- R5: At the end of a read phase, S is stored as the partial sum of the commanded subset for that node. Subset code 0 means structured and 1 means random. A later pass of the opposite subset on the same node uses that value.
- R6: Outputs saturate to the range -128..127.
- R7: `in_ready` and `out_valid` are never high in the same cycle. No output is offered before all inputs of the pass have been taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_msg` stays unchanged in the next cycle.
- R9: `done` is high for one cycle, in the cycle right after the last output transfer. A `start` in that cycle is accepted.
- R10: A `start` with degree 0 takes no inputs and gives no outputs. It raises `done` in the next cycle and leaves every stored partial sum unchanged.
- R11: A write on the LLR port while idle replaces the LLR of the addressed node, and later passes on that node use the new value.
- R12: With no stalls on either stream, the last output transfer of a degree-d pass comes 2d-1 cycles after its first input transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llr_we | input | 1 | Channel LLR write strobe |
| llr_addr | input | clog2(NODES) | Node written by the LLR port |
| llr_data | input | MSG_W | Channel LLR value, two's complement |
| start | input | 1 | Begin a pass (taken only when idle) |
| start_node | input | clog2(NODES) | Node served by the pass |
| start_subset | input | 1 | 0 = structured edges, 1 = random edges |
| start_degree | input | clog2(MAX_DEG+1) | Number of edges in the pass |
| in_valid | input | 1 | Incoming check message valid |
| in_ready | output | 1 | Block can take an incoming message |
| in_msg | input | MSG_W | Incoming check-to-variable message |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Downstream can take the outgoing message |
| out_msg | output | MSG_W | Outgoing variable-to-check message |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The hardest case to reach is a pass that depends on state left behind by earlier passes. This happens when one subset's pass uses the partial sum stored by the other subset's pass on the same node, possibly with a degree-0 pass or an LLR reload in between. The stimulus alternates structured and random passes on one node, so each output depends on a total recorded several passes earlier. It also places a stray `start` inside an open read phase, and runs passes with output back-pressure and gaps in the input stream. This stalls the write phase in the middle, which checks that the held message and the edge order both survive the stall.

// File: rtl/svp_pkg.sv
package svp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/svp_edge_buf.sv
// Keeps the inputs of one pass so outputs can be formed in arrival order.
module svp_edge_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [W-1:0]             rd_data
);
  logic [W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  assign rd_data = slot_q[rd_idx];

  // R3
  buf_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < DEPTH));
endmodule

// File: rtl/svp_node_store.sv
// Per-node channel LLR and the two per-subset partial sums.
module svp_node_store #(
  parameter int MSG_W = 8,
  parameter int SUM_W = 12,
  parameter int NODES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        llr_we,
  input  logic [$clog2(NODES)-1:0]    llr_addr,
  input  logic [MSG_W-1:0]            llr_data,
  input  logic                        part_we,
  input  logic                        part_sub,
  input  logic signed [SUM_W-1:0]     part_wdata,
  input  logic [$clog2(NODES)-1:0]    node,
  input  logic                        rd_sub,
  output logic [MSG_W-1:0]            llr_rd,
  output logic signed [SUM_W-1:0]     part_rd
);
  logic [MSG_W-1:0]        llr_q  [NODES];
  logic signed [SUM_W-1:0] part_q [2][NODES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NODES; n++) begin
        llr_q[n]     <= '0;
        part_q[0][n] <= '0;
        part_q[1][n] <= '0;
      end
    end else begin
      if (llr_we)  llr_q[llr_addr] <= llr_data;
      if (part_we) part_q[part_sub][node] <= part_wdata;
    end
  end

  assign llr_rd  = llr_q[node];
  assign part_rd = part_q[rd_sub][node];

  // R11
  llr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    llr_we |-> !$isunknown(llr_addr));
endmodule

// File: rtl/svp_extrinsic.sv
// Extrinsic output: llr + own sum + other sum - edge, clipped to MSG_W bits.
module svp_extrinsic #(
  parameter int MSG_W = 8,
  parameter int SUM_W = 12
) (
  input  logic [MSG_W-1:0]        llr,
  input  logic signed [SUM_W-1:0] own_sum,
  input  logic signed [SUM_W-1:0] other_sum,
  input  logic [MSG_W-1:0]        edge_msg,
  output logic [MSG_W-1:0]        ext_msg
);
  localparam int TOT_W = SUM_W + 2;
  localparam logic signed [TOT_W-1:0] POS_LIM = TOT_W'((1 << (MSG_W-1)) - 1);
  localparam logic signed [TOT_W-1:0] NEG_LIM = -POS_LIM - TOT_W'(1);

  logic signed [TOT_W-1:0] llr_x, own_x, oth_x, edge_x, total;

  assign llr_x  = {{(TOT_W-MSG_W){llr[MSG_W-1]}}, llr};
  assign edge_x = {{(TOT_W-MSG_W){edge_msg[MSG_W-1]}}, edge_msg};
  assign own_x  = {{2{own_sum[SUM_W-1]}}, own_sum};
  assign oth_x  = {{2{other_sum[SUM_W-1]}}, other_sum};
  assign total  = llr_x + own_x + oth_x - edge_x;

  always_comb begin
    if (total > POS_LIM)      ext_msg = POS_LIM[MSG_W-1:0];
    else if (total < NEG_LIM) ext_msg = NEG_LIM[MSG_W-1:0];
    else                      ext_msg = total[MSG_W-1:0];
  end
endmodule

// File: rtl/split_vnode_proc.sv
module split_vnode_proc
  import svp_pkg::*;
#(
  parameter int MSG_W   = 8,
  parameter int MAX_DEG = 8,
  parameter int NODES   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           llr_we,
  input  logic [$clog2(NODES)-1:0]       llr_addr,
  input  logic [MSG_W-1:0]               llr_data,
  input  logic                           start,
  input  logic [$clog2(NODES)-1:0]       start_node,
  input  logic                           start_subset,
  input  logic [$clog2(MAX_DEG+1)-1:0]   start_degree,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [MSG_W-1:0]               in_msg,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [MSG_W-1:0]               out_msg,
  output logic                           done
);
  localparam int NODE_W = $clog2(NODES);
  localparam int DEG_W  = $clog2(MAX_DEG + 1);
  localparam int IDX_W  = $clog2(MAX_DEG);
  localparam int SUM_W  = MSG_W + $clog2(MAX_DEG) + 1;

  phase_e                  phase_q;
  logic [NODE_W-1:0]       node_q;
  logic                    sub_q;
  logic [DEG_W-1:0]        deg_q;
  logic [IDX_W-1:0]        idx_q;
  logic signed [SUM_W-1:0] acc_q;
  logic                    done_q;

  logic                    idle, rd_fire, wr_fire, last_edge;
  logic signed [SUM_W-1:0] in_ext, acc_next, other_sum;
  logic [MSG_W-1:0]        llr_val, edge_msg;

  assign idle      = (phase_q == PH_IDLE);
  assign in_ready  = (phase_q == PH_READ);
  assign out_valid = (phase_q == PH_WRITE);
  assign done      = done_q;
  assign rd_fire   = in_valid && in_ready;
  assign wr_fire   = out_valid && out_ready;
  assign last_edge = (DEG_W'(idx_q) == deg_q - DEG_W'(1));
  assign in_ext    = {{(SUM_W-MSG_W){in_msg[MSG_W-1]}}, in_msg};
  assign acc_next  = acc_q + in_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      node_q  <= '0;
      sub_q   <= 1'b0;
      deg_q   <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          node_q <= start_node;
          sub_q  <= start_subset;
          deg_q  <= start_degree;
          idx_q  <= '0;
          acc_q  <= '0;
          if (start_degree == '0) done_q  <= 1'b1;
          else                    phase_q <= PH_READ;
        end
        PH_READ: if (rd_fire) begin
          acc_q <= acc_next;
          if (last_edge) begin
            phase_q <= PH_WRITE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        PH_WRITE: if (wr_fire) begin
          if (last_edge) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  svp_edge_buf #(.W(MSG_W), .DEPTH(MAX_DEG)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rd_fire),
    .wr_idx  (idx_q),
    .wr_data (in_msg),
    .rd_idx  (idx_q),
    .rd_data (edge_msg)
  );

  svp_node_store #(.MSG_W(MSG_W), .SUM_W(SUM_W), .NODES(NODES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .llr_we     (llr_we),
    .llr_addr   (llr_addr),
    .llr_data   (llr_data),
    .part_we    (rd_fire && last_edge),
    .part_sub   (sub_q),
    .part_wdata (acc_next),
    .node       (node_q),
    .rd_sub     (~sub_q),
    .llr_rd     (llr_val),
    .part_rd    (other_sum)
  );

  svp_extrinsic #(.MSG_W(MSG_W), .SUM_W(SUM_W)) u_ext (
    .llr       (llr_val),
    .own_sum   (acc_q),
    .other_sum (other_sum),
    .edge_msg  (edge_msg),
    .ext_msg   (out_msg)
  );

  // R7
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msg)));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) || $past(idle && start && start_degree == '0)));

  // R3
  read_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && last_edge) |=> out_valid);

  // R10
  deg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |-> (int'(start_degree) <= MAX_DEG));
endmodule

// File: tb/split_vnode_proc_tb.sv
`timescale 1ns/1ps
module split_vnode_proc_tb;
  localparam int MSG_W = 8, MAX_DEG = 8, NODES = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, llr_we, start, start_subset, in_valid, in_ready, out_valid, out_ready, done;
  logic [3:0] llr_addr, start_node, start_degree;
  logic [7:0] llr_data, in_msg, out_msg;

  split_vnode_proc #(.MSG_W(MSG_W), .MAX_DEG(MAX_DEG), .NODES(NODES)) u_dut (
    .clk(clk), .rst_n(rst_n), .llr_we(llr_we), .llr_addr(llr_addr), .llr_data(llr_data),
    .start(start), .start_node(start_node), .start_subset(start_subset),
    .start_degree(start_degree), .in_valid(in_valid), .in_ready(in_ready), .in_msg(in_msg),
    .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg), .done(done));

  int errs = 0, checks = 0, cyc = 0;
  int exp_q[$];
  int llr_m[NODES];
  int part_m[NODES][2];
  int msg_a[MAX_DEG];
  int first_in = -1, last_out = -1;
  bit bp_mode = 0, gap_mode = 0;
  string cur_req = "R4";
  logic pv = 0, pr = 0;
  logic [7:0] pm = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clip8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // cycle count, output back-pressure pattern, watchdog
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    if (cyc == 150000) begin
      errs++; checks++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // per-clock comparison against the reference queue
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(in_ready && out_valid), "R7", int'(in_ready && out_valid), 0);
      if (pv && !pr)
        chk(out_valid && out_msg == pm, "R8", int'($signed(out_msg)), int'($signed(pm)));
      if (in_valid && in_ready && first_in < 0) first_in = cyc;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R7", int'($signed(out_msg)), -999);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'($signed(out_msg)) == e, cur_req, int'($signed(out_msg)), e);
        end
        last_out = cyc;
      end
      pv = out_valid; pr = out_ready; pm = out_msg;
    end
  end

  task automatic load_llr(int node, int val);
    @(posedge clk); #1;
    llr_we = 1; llr_addr = 4'(node); llr_data = 8'(val);
    @(posedge clk); #1;
    llr_we = 0;
    llr_m[node] = val;
  endtask

  task automatic run_node(int node, int sub, int deg, bit noise);
    int sum = 0, other, w = 0, lo;
    for (int i = 0; i < deg; i++) sum += msg_a[i];
    if (deg > 0) part_m[node][sub] = sum;
    other = part_m[node][1-sub];
    for (int i = 0; i < deg; i++) exp_q.push_back(clip8(llr_m[node] + sum + other - msg_a[i]));
    first_in = -1; lo = last_out;
    start = 1; start_node = 4'(node); start_subset = sub[0]; start_degree = 4'(deg);
    @(posedge clk); #1;
    start = 0;
    for (int i = 0; i < deg; i++) begin
      if (gap_mode && (i % 2 == 1)) begin
        in_valid = 0; @(posedge clk); #1;
      end
      in_valid = 1; in_msg = 8'(msg_a[i]);
      if (noise && i == 1) begin   // R2: stray start while busy
        start = 1; start_node = 4'((node + 1) % NODES); start_subset = ~sub[0]; start_degree = 4'd3;
      end
      forever begin @(negedge clk); if (in_ready) break; end
      @(posedge clk); #1;
      start = 0;
    end
    in_valid = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      w++;
      if (w > 400) begin chk(0, "R9", 0, 1); break; end
    end
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
    exp_q.delete();
    if (deg > 0) chk(last_out == cyc - 1, "R9", last_out, cyc - 1);
    else begin
      chk(first_in < 0, "R10", first_in, -1);
      chk(last_out == lo, "R10", last_out, lo);
    end
    if (deg > 0 && !bp_mode && !gap_mode)
      chk(last_out - first_in == 2*deg - 1, "R12", last_out - first_in, 2*deg - 1);
  endtask

  initial begin
    rst_n = 0; llr_we = 0; llr_addr = 0; llr_data = 0; start = 0; start_node = 0;
    start_subset = 0; start_degree = 0; in_valid = 0; in_msg = 0; out_ready = 1;
    for (int n = 0; n < NODES; n++) begin llr_m[n] = 0; part_m[n][0] = 0; part_m[n][1] = 0; end
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R1", int'(out_valid), 0);
    chk(!in_ready, "R1", int'(in_ready), 0);
    chk(!done, "R1", int'(done), 0);

    for (int n = 0; n < NODES; n++) load_llr(n, ((n * 37) % 200) - 100);

    // R1 / R4: first pass uses a zero random partial sum
    cur_req = "R4";
    msg_a[0] = 10; msg_a[1] = -20; msg_a[2] = 35; msg_a[3] = 7;
    run_node(3, 0, 4, 0);
    // R5: random pass uses stored structured sum
    cur_req = "R5";
    msg_a[0] = -5; msg_a[1] = 60; msg_a[2] = -12;
    run_node(3, 1, 3, 0);
    msg_a[0] = 1; msg_a[1] = 2;
    run_node(3, 0, 2, 0);

    // R8: back-pressure with input gaps
    cur_req = "R8";
    bp_mode = 1; gap_mode = 1;
    for (int i = 0; i < MAX_DEG; i++) msg_a[i] = i * 23 - 90;
    run_node(7, 1, 8, 0);
    bp_mode = 0; gap_mode = 0;

    // R6: saturation both ways
    cur_req = "R6";
    load_llr(9, 120);
    for (int i = 0; i < MAX_DEG; i++) msg_a[i] = 127;
    run_node(9, 0, 8, 0);
    load_llr(10, -128);
    for (int i = 0; i < MAX_DEG; i++) msg_a[i] = -128;
    run_node(10, 1, 8, 0);

    // R2: stray start during read phase
    cur_req = "R2";
    msg_a[0] = 4; msg_a[1] = -9; msg_a[2] = 33; msg_a[3] = -70; msg_a[4] = 15;
    run_node(5, 0, 5, 0);
    run_node(5, 1, 5, 1);

    // R10: degree-0 pass keeps stored sums
    cur_req = "R10";
    run_node(3, 1, 0, 0);
    msg_a[0] = 50;
    run_node(3, 0, 1, 0);

    // R11: LLR reload
    cur_req = "R11";
    load_llr(3, 77);
    msg_a[0] = -3; msg_a[1] = 19;
    run_node(3, 1, 2, 0);

    // R4: mixed random passes
    cur_req = "R4";
    for (int k = 0; k < 24; k++) begin
      int nd, sb, dg;
      bp_mode = (k % 2 == 1); gap_mode = (k % 3 == 0);
      nd = $urandom_range(0, NODES-1); sb = $urandom_range(0, 1); dg = $urandom_range(1, MAX_DEG);
      for (int i = 0; i < MAX_DEG; i++) msg_a[i] = int'($urandom_range(0, 255)) - 128;
      run_node(nd, sb, dg, 0);
    end
    bp_mode = 0; gap_mode = 0;

    repeat (3) @(posedge clk);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule